// File: doc/BRIEF.md
# Single-Master I2C Bus Controller

This block sits between a small parallel register port and a two-wire serial bus on which it is the only master. Software writes a control register to request a START or a STOP condition, and writes the data register to send one byte or to fetch one. The block produces SCL from a quarter-period divider at one of two rates that software selects. It shifts each byte most significant bit first and runs a ninth clock pulse for the acknowledge bit.

When the acknowledge pulse ends, a byte-done flag is set. Software can poll this flag, or an interrupt output can report it when the interrupt enable bit is set. The block changes between idle and bus-master state by itself: it becomes master once its START has been generated and returns to idle once its STOP has been generated. The least significant bit of the first byte after a START is the read/write bit. It sets the direction of the later bytes, and a status bit shows that direction. Both bus lines are open-drain and are modelled as pull-low enables. The received data line is sampled in the middle of the SCL high phase.

Top module: `i2cm_top`

## Requirements
- R1: After reset both pull-low outputs are inactive, the interrupt is low, and the status and control registers read as zero. Register addresses: 0 is control, 1 is status, 2 is data.
- R2: A control write with bit 0 set, made while no sequence runs, produces a START: SDA falls while SCL is high, then SCL is pulled low. Status bit 2 (master) and status bit 1 (transmitter) are then 1. Repeated START from master state is allowed.
- R3: In transmit direction, a data write shifts the byte onto SDA MSB first over 8 SCL pulses. A ninth pulse follows on which SDA is released. Status bit 3 records the level sampled on that pulse (1 = not acknowledged).
- R4: The byte sent first after a START is the address. Once its acknowledge pulse ends, status bit 1 becomes the inverse of that byte's bit 0, so a read/write bit of 1 turns the block into a receiver.
- R5: In receive direction, a data write (value ignored) clocks in 8 bits MSB first, each sampled at mid-high of SCL. On the ninth pulse the block pulls SDA low when control bit 2 is 1 and releases it otherwise. A data read returns the received byte.
- R6: Status bit 0 (byte done) is set when the ninth pulse ends. It is cleared by a data write, or by a data read whose previous register access was a status read. A data read after any other access leaves it set.
- R7: The interrupt output equals byte done gated by control bit 4.
- R8: A control write with bit 1 set (bit 0 clear), made in master state with no sequence running, produces a STOP: SDA rises while SCL is high. Status bits 2 and 1 then clear and both lines are released. A STOP request outside master state is ignored.
- R9: Control bit 3 selects fast rate. Each SCL high phase lasts two quarter periods: 2*STD_QTR clock cycles at standard rate and 2*FAST_QTR at fast rate.
- R10: SDA changes only while SCL is low, except for the START and STOP edges.
- R11: If a byte completes in the same cycle as a register access that would clear byte done, the flag ends up set.
- R12: Commands and data writes made while a sequence runs (status bit 4 = 1) are ignored. A data write outside master state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for the register selected by regAddr |
| irq | output | 1 | Byte-done interrupt |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | Pulls SCL low when 1 |
| sdaOe | output | 1 | Pulls SDA low when 1 |

## Verification
Two events can fall on the same clock edge: the end of the acknowledge pulse, which sets byte done, and a software data-register access, which clears it. The bench provokes this by holding a data write asserted on every cycle while a byte is in flight. One of those writes is bound to land on the completion edge. The bench releases the write the first time the interrupt is seen. It then expects the flag to be set, no sequence to be running, and exactly one byte on the bus. A lost flag would appear as a missing interrupt or as a second, unexpected byte that the bus monitor reports.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_START = 3'd1,
    SQ_BIT   = 3'd2,
    SQ_ACK   = 3'd3,
    SQ_STOP  = 3'd4
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic tickEn;
    logic fastSel;
    logic load;
    logic shift;
    logic sample;
    logic sclPull;
    logic sdaPull;
    logic sdaFromSh;
  } dpCtl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register bits
  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_ACK   = 2;
  localparam int CB_FAST  = 3;
  localparam int CB_IRQ   = 4;
  localparam int CTRL_W   = 5;

endpackage

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int STD_QTR  = 312,
  parameter int FAST_QTR = 78
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] loadData,
  input  logic       sdaIn,
  output logic       tick,
  output logic       sampBit,
  output logic [7:0] shReg,
  output logic       sclOe,
  output logic       sdaOe
);

  localparam int MAXQ  = (STD_QTR > FAST_QTR) ? STD_QTR : FAST_QTR;
  localparam int CNT_W = $clog2(MAXQ) + 1;
  localparam logic [CNT_W-1:0] STD_LAST  = CNT_W'(STD_QTR - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_QTR - 1);

  logic [CNT_W-1:0] qCnt;
  logic [CNT_W-1:0] qLast;

  assign qLast = ctl.fastSel ? FAST_LAST : STD_LAST;
  assign tick  = ctl.tickEn && (qCnt == qLast);

  // quarter-period divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            qCnt <= '0;
    else if (!ctl.tickEn) qCnt <= '0;
    else if (tick)        qCnt <= '0;
    else                  qCnt <= qCnt + 1'b1;
  end

  // shift register and bit sampler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      sampBit <= 1'b1;
    end else begin
      if (ctl.load)       shReg <= loadData;
      else if (ctl.shift) shReg <= {shReg[6:0], sampBit};
      if (ctl.sample)     sampBit <= sdaIn;
    end
  end

  // registered open-drain enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
    end else begin
      sclOe <= ctl.sclPull;
      sdaOe <= ctl.sdaFromSh ? ~shReg[7] : ctl.sdaPull;
    end
  end

  // R5: the line is sampled only while SCL is released
  p_sample_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sample |-> !sclOe);

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [CTRL_W-1:0] regWbits,
  output logic [7:0]        regRdata,
  output logic              irq,
  input  logic              tick,
  input  logic              sampBit,
  input  logic [7:0]        shReg,
  output dpCtl_t            dpCtl,
  output logic              inCond
);

  seqState_t  state;
  logic [1:0] phase;
  logic [2:0] bitCnt;
  logic busMaster, txMode, addrPend, rwBit, nack, byteDone, lastStatRd;
  logic ackOn, fastSel, irqEn;

  logic wrCtrl, wrData, rdStat, rdData, seqIdle;
  logic startAcc, stopAcc, dataAcc, phaseEnd, ackEnd;

  assign wrCtrl   = regWr && (regAddr == ADDR_CTRL);
  assign wrData   = regWr && (regAddr == ADDR_DATA);
  assign rdStat   = regRd && (regAddr == ADDR_STAT);
  assign rdData   = regRd && (regAddr == ADDR_DATA);
  assign seqIdle  = (state == SQ_IDLE);
  assign startAcc = wrCtrl && regWbits[CB_START] && seqIdle;
  assign stopAcc  = wrCtrl && regWbits[CB_STOP] && !regWbits[CB_START]
                    && seqIdle && busMaster;
  assign dataAcc  = wrData && seqIdle && busMaster;
  assign phaseEnd = tick && (phase == 2'd3);
  assign ackEnd   = (state == SQ_ACK) && phaseEnd;
  assign inCond   = (state == SQ_START) || (state == SQ_STOP);
  assign irq      = byteDone && irqEn;

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SQ_IDLE;
      phase     <= 2'd0;
      bitCnt    <= 3'd0;
      busMaster <= 1'b0;
      txMode    <= 1'b0;
      addrPend  <= 1'b0;
      rwBit     <= 1'b0;
      nack      <= 1'b0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          phase <= 2'd0;
          if (startAcc) begin
            state <= SQ_START;
          end else if (stopAcc) begin
            state <= SQ_STOP;
          end else if (dataAcc) begin
            state  <= SQ_BIT;
            bitCnt <= 3'd0;
            if (addrPend) rwBit <= regWbits[0];
          end
        end
        SQ_START: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            state     <= SQ_IDLE;
            busMaster <= 1'b1;
            txMode    <= 1'b1;
            addrPend  <= 1'b1;
          end
        end
        SQ_BIT: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (bitCnt == 3'd7) state <= SQ_ACK;
            else                bitCnt <= bitCnt + 3'd1;
          end
        end
        SQ_ACK: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            state <= SQ_IDLE;
            if (txMode) nack <= sampBit;
            if (addrPend) begin
              addrPend <= 1'b0;
              txMode   <= !rwBit;
            end
          end
        end
        SQ_STOP: if (tick) begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            state     <= SQ_IDLE;
            busMaster <= 1'b0;
            txMode    <= 1'b0;
            addrPend  <= 1'b0;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // configuration bits, flag and access history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOn      <= 1'b0;
      fastSel    <= 1'b0;
      irqEn      <= 1'b0;
      byteDone   <= 1'b0;
      lastStatRd <= 1'b0;
    end else begin
      if (wrCtrl) begin
        ackOn   <= regWbits[CB_ACK];
        fastSel <= regWbits[CB_FAST];
        irqEn   <= regWbits[CB_IRQ];
      end
      if (ackEnd)                              byteDone <= 1'b1;
      else if (wrData || (rdData && lastStatRd)) byteDone <= 1'b0;
      if (rdStat)              lastStatRd <= 1'b1;
      else if (regRd || regWr) lastStatRd <= 1'b0;
    end
  end

  // strobes towards the datapath
  always_comb begin
    dpCtl           = '0;
    dpCtl.tickEn    = !seqIdle;
    dpCtl.fastSel   = fastSel;
    dpCtl.load      = dataAcc;
    dpCtl.shift     = (state == SQ_BIT) && phaseEnd;
    dpCtl.sample    = ((state == SQ_BIT) || (state == SQ_ACK)) && tick && (phase == 2'd2);
    unique case (state)
      SQ_IDLE: begin
        dpCtl.sclPull = busMaster;
      end
      SQ_START: begin
        dpCtl.sclPull = (phase == 2'd0) ? busMaster : (phase == 2'd3);
        dpCtl.sdaPull = phase[1];
      end
      SQ_BIT: begin
        dpCtl.sclPull   = !phase[1];
        dpCtl.sdaFromSh = txMode;
      end
      SQ_ACK: begin
        dpCtl.sclPull = !phase[1];
        dpCtl.sdaPull = !txMode && ackOn;
      end
      SQ_STOP: begin
        dpCtl.sclPull = (phase == 2'd0);
        dpCtl.sdaPull = !phase[1];
      end
      default: dpCtl.sclPull = 1'b0;
    endcase
  end

  // register read mux
  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdata = {3'b000, irqEn, fastSel, ackOn, 2'b00};
      ADDR_STAT: regRdata = {3'b000, !seqIdle, nack, busMaster, txMode, byteDone};
      ADDR_DATA: regRdata = shReg;
      default:   regRdata = 8'h00;
    endcase
  end

  p_start_master_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_START && phaseEnd) |=> (busMaster && txMode));

  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_STOP && phaseEnd) |=> (!busMaster && state == SQ_IDLE));

  p_done_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    ackEnd |=> byteDone);

  p_bit_undisturbed_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == SQ_BIT && !tick) |=> (state == SQ_BIT));

endmodule

// File: rtl/i2cm_top.sv
module i2cm_top
  import i2cm_pkg::*;
#(
  parameter int STD_QTR  = 312,
  parameter int FAST_QTR = 78
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       irq,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);

  dpCtl_t     dpCtl;
  logic       tick;
  logic       sampBit;
  logic [7:0] shReg;
  logic       inCond;

  i2cm_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWbits (regWdata[CTRL_W-1:0]),
    .regRdata (regRdata),
    .irq      (irq),
    .tick     (tick),
    .sampBit  (sampBit),
    .shReg    (shReg),
    .dpCtl    (dpCtl),
    .inCond   (inCond)
  );

  i2cm_datapath #(
    .STD_QTR  (STD_QTR),
    .FAST_QTR (FAST_QTR)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (dpCtl),
    .loadData (regWdata),
    .sdaIn    (sdaIn),
    .tick     (tick),
    .sampBit  (sampBit),
    .shReg    (shReg),
    .sclOe    (sclOe),
    .sdaOe    (sdaOe)
  );

  // R10: data moves under a released clock only inside START/STOP
  p_sda_scl_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !sclOe && !$past(sclOe)) |-> inCond);

endmodule

// File: tb/i2cm_top_tb_top.sv
module i2cm_top_tb_top;

  localparam int STDQ  = 6;
  localparam int FASTQ = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0, regRd = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       irq, sclOe, sdaOe;
  logic       slvPull = 1'b0;
  logic       sdaLine, sclLine;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = !(sdaOe || slvPull);
  assign sclLine = !sclOe;

  i2cm_top #(.STD_QTR(STDQ), .FAST_QTR(FASTQ)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  // scoreboard: {kind, ack, data}; kind 1 START, 2 STOP, 3 byte
  logic [10:0] expQ[$];
  string       tagQ[$];
  logic [7:0]  slvRdQ[$];
  logic        slvAckEn = 1'b1;
  int          lastHigh = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic pushExp(input logic [1:0] k, input logic a, input logic [7:0] d, input string t);
    expQ.push_back({k, a, d});
    tagQ.push_back(t);
  endtask

  task automatic busEvent(input logic [10:0] got);
    logic [10:0] e;
    string t;
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL R10 unexpected bus event got %h exp none", got);
    end else begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      if (got !== e) begin
        errors++;
        $display("FAIL %s bus event got %h exp %h", t, got, e);
      end
    end
  endtask

  // monitor and slave model, sampled away from the active edge
  logic       pScl = 1'b1, pSda = 1'b1;
  int         bitIdx = 0, byteIdx = 0, hiCnt = 0;
  logic [7:0] shiftByte = 8'h00, curRd = 8'h00;
  logic       rdMode = 1'b0, rdActive = 1'b0;

  always @(negedge clk) begin
    if (sclLine) hiCnt++;
    if (pScl && sclLine && pSda && !sdaLine) begin
      busEvent({2'd1, 1'b0, 8'h00});
      bitIdx = 0; byteIdx = 0; rdMode = 1'b0; rdActive = 1'b0; slvPull = 1'b0;
    end else if (pScl && sclLine && !pSda && sdaLine) begin
      busEvent({2'd2, 1'b0, 8'h00});
      bitIdx = 0; byteIdx = 0; rdMode = 1'b0; rdActive = 1'b0; slvPull = 1'b0;
    end else if (!pScl && sclLine) begin
      if (bitIdx < 8) begin
        shiftByte = {shiftByte[6:0], sdaLine};
        bitIdx++;
      end else begin
        busEvent({2'd3, sdaLine, shiftByte});
        if (byteIdx == 0) begin
          rdMode   = shiftByte[0];
          rdActive = shiftByte[0] && !sdaLine;
        end else begin
          rdActive = rdMode && !sdaLine;
        end
        if (rdActive && slvRdQ.size() > 0) curRd = slvRdQ.pop_front();
        byteIdx++;
        bitIdx = 0;
      end
    end else if (pScl && !sclLine) begin
      lastHigh = hiCnt;
      if (bitIdx == 8)
        slvPull = (rdMode && byteIdx > 0) ? 1'b0 : slvAckEn;
      else if (rdMode && byteIdx > 0 && rdActive)
        slvPull = !curRd[7 - bitIdx];
      else
        slvPull = 1'b0;
    end
    if (!sclLine) hiCnt = 0;
    pScl = sclLine;
    pSda = sdaLine;
  end

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    s = 8'h10;
    for (int i = 0; i < 5000 && s[4]; i++) regRead(2'd1, s);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog expired got 1 exp 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    int guard;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 sclOe", sclOe, 0);
    chk("R1 sdaOe", sdaOe, 0);
    chk("R1 irq", irq, 0);
    regRead(2'd1, v); chk("R1 status", v, 8'h00);
    regRead(2'd0, v); chk("R1 control", v, 8'h00);

    // START, address byte for write
    regWrite(2'd0, 8'h14);
    pushExp(2'd1, 1'b0, 8'h00, "R2");
    regWrite(2'd0, 8'h15);
    waitIdle();
    regRead(2'd1, v); chk("R2 master+tx", v & 8'h16, 8'h06);
    pushExp(2'd3, 1'b0, 8'hA6, "R3");
    regWrite(2'd2, 8'hA6);
    waitIdle();
    chk("R7 irq on done", irq, 1);
    regRead(2'd1, v);
    chk("R6 done set", v[0], 1);
    chk("R3 ack seen", v[3], 0);
    chk("R4 stays tx", v[1], 1);

    // R6: data read not preceded by a status read keeps the flag
    regRead(2'd0, v);
    regRead(2'd2, v); chk("R3 data readback", v, 8'hA6);
    chk("R6 kept after plain read", irq, 1);
    regRead(2'd1, v);
    regRead(2'd2, v);
    chk("R6 cleared by status+data", irq, 0);

    // not acknowledged byte; START during it is ignored
    slvAckEn = 1'b0;
    pushExp(2'd3, 1'b1, 8'h3C, "R3");
    regWrite(2'd2, 8'h3C);
    regWrite(2'd0, 8'h15);
    waitIdle();
    slvAckEn = 1'b1;
    regRead(2'd1, v);
    chk("R3 nack recorded", v[3], 1);
    chk("R12 still master", v[2], 1);
    regWrite(2'd0, 8'h04);
    chk("R7 irq masked", irq, 0);
    regWrite(2'd0, 8'h14);
    chk("R7 irq unmasked", irq, 1);

    // R11: data write held on every cycle through completion
    pushExp(2'd3, 1'b0, 8'h81, "R11");
    @(negedge clk);
    regWr = 1'b1; regAddr = 2'd2; regWdata = 8'h81;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!irq && guard < 2000);
    regWr = 1'b0;
    regRead(2'd1, v);
    chk("R11 flag survives clear", v & 8'h11, 8'h01);

    // repeated START, address for read, two received bytes
    slvRdQ.push_back(8'hC5);
    slvRdQ.push_back(8'h3A);
    pushExp(2'd1, 1'b0, 8'h00, "R2");
    regWrite(2'd0, 8'h15);
    waitIdle();
    pushExp(2'd3, 1'b0, 8'hA7, "R4");
    regWrite(2'd2, 8'hA7);
    waitIdle();
    regRead(2'd1, v); chk("R4 receiver", v[1], 0);
    pushExp(2'd3, 1'b0, 8'hC5, "R5");
    regWrite(2'd2, 8'h00);
    waitIdle();
    regRead(2'd1, v);
    regRead(2'd2, v); chk("R5 first byte", v, 8'hC5);
    regWrite(2'd0, 8'h10);
    pushExp(2'd3, 1'b1, 8'h3A, "R5");
    regWrite(2'd2, 8'hFF);
    waitIdle();
    regRead(2'd2, v); chk("R5 second byte", v, 8'h3A);
    chk("R9 std high time", lastHigh, 2 * STDQ);

    // STOP
    pushExp(2'd2, 1'b0, 8'h00, "R8");
    regWrite(2'd0, 8'h12);
    waitIdle();
    regRead(2'd1, v); chk("R8 idle", v & 8'h16, 8'h00);
    chk("R8 lines released", {sclOe, sdaOe}, 2'b00);
    regWrite(2'd0, 8'h12);
    regRead(2'd1, v); chk("R8 stop ignored", v[4], 0);
    regWrite(2'd2, 8'h55);
    regRead(2'd1, v); chk("R12 data ignored idle", v[4], 0);

    // fast rate transaction
    regWrite(2'd0, 8'h1C);
    pushExp(2'd1, 1'b0, 8'h00, "R9");
    regWrite(2'd0, 8'h1D);
    waitIdle();
    pushExp(2'd3, 1'b0, 8'hA0, "R9");
    regWrite(2'd2, 8'hA0);
    waitIdle();
    chk("R9 fast high time", lastHigh, 2 * FASTQ);
    pushExp(2'd2, 1'b0, 8'h00, "R9");
    regWrite(2'd0, 8'h1E);
    waitIdle();

    repeat (20) @(negedge clk);
    chk("R10 all bus events seen", expQ.size(), 0);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule